// File: doc/BRIEF.md
# APB Master Transfer Controller

This block is the requester side of a peripheral bus. It takes single commands over a valid/ready handshake and runs each one as an APB transfer to one of several peripherals. Each command carries an address, a write flag, write data and a binary slave index. The controller drives the address, a one-hot select vector, the enable strobe, the direction line and the write data. It samples the peripheral's ready, read data and error inputs.

Every transfer passes through a one-cycle setup phase and then an access phase. The access phase lasts as long as the peripheral holds ready low. When a transfer completes, a one-cycle response pulse returns the read data and the error flag. If another command is waiting at that moment, the controller accepts it in the same cycle and goes straight into the next setup phase, with no idle cycle in between.

Top module: `apb_xfer_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, after that edge `bus_sel` is all zero, `bus_en` is low, `rsp_valid` is low and `cmd_ready` is high (controller idle).
- R2: `cmd_sel` is a binary index below `NUM_SLV`. While a transfer is in progress, exactly bit `cmd_sel` of `bus_sel` is high. In idle, `bus_sel` is zero.
- R3: In the cycle after a command is accepted, `bus_sel` is asserted and `bus_en` is low (setup phase). `bus_en` rises on the next clock edge.
- R4: `bus_addr`, `bus_sel`, `bus_wr` and `bus_wdata` keep the values of the accepted command from the setup cycle until the transfer completes.
- R5: While `bus_en` is high and `bus_rdy` is low, the controller stays in the access phase for as many cycles as `bus_rdy` stays low.
- R6: A transfer completes at a clock edge where `bus_en` and `bus_rdy` are both high. If no command is accepted at that edge, `bus_sel` and `bus_en` are both low in the next cycle.
- R7: If a command is accepted at the completing edge, the next cycle is directly a setup cycle for the new command: the new select bit is set and `bus_en` is low.
- R8: In the cycle after each completion, and only then, `rsp_valid` is high for one cycle. For a read, `rsp_rdata` carries the `bus_rdata` value sampled at completion. For a write, `rsp_rdata` is zero.
- R9: `rsp_err` in the response cycle equals `bus_err` sampled at the completing edge, for both reads and writes.
- R10: `cmd_ready` is high only when the controller is idle, or in the access phase while `bus_rdy` is high.
- R11: `bus_wr` equals the accepted `cmd_write` (1 = write, 0 = read). `bus_wdata` carries `cmd_wdata` for writes and zero for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid` |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Write data |
| cmd_sel | input | IDX_W | Binary index of target peripheral |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data of the completed transfer (zero for writes) |
| rsp_err | output | 1 | Error flag of the completed transfer |
| bus_addr | output | ADDR_W | Bus address |
| bus_sel | output | NUM_SLV | One-hot peripheral select |
| bus_en | output | 1 | Enable strobe, high in the access phase |
| bus_wr | output | 1 | Transfer direction |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdy | input | 1 | Peripheral ready, stretches the access phase when low |
| bus_rdata | input | DATA_W | Peripheral read data |
| bus_err | input | 1 | Peripheral error flag, tied low when a peripheral lacks one |

## Verification
The hardest case to reach is a completing access phase that has a command waiting at that very edge. Here the completion, the response and the acceptance of the next command all share one clock edge. The next command must begin without an idle cycle, and the held bus values must switch cleanly to the new command. To reach this, one stimulus phase keeps commands present and the peripheral always ready, so transfers run back to back. Two other phases use different ready probabilities to produce both long wait runs and mixed traffic. A reset during live transfers is also applied. A cycle model in the bench checks every output on every cycle. At the end, the bench confirms that back-to-back handoffs and waits of ten cycles or more both occurred.

// File: rtl/apb_xfer_ctrl.sv
module apb_xfer_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_SLV = 4,
  localparam int IDX_W  = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [IDX_W-1:0]  cmd_sel,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_SLV-1:0] bus_sel,
  output logic              bus_en,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACCESS} state_t;

  state_t             state, state_nx;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [NUM_SLV-1:0] sel_q;
  logic [NUM_SLV-1:0] sel_dec;
  logic               finish;
  logic               take;

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_dec
    assign sel_dec[i] = (cmd_sel == IDX_W'(i));
  end

  assign finish    = (state == ST_ACCESS) && bus_rdy;
  assign cmd_ready = (state == ST_IDLE) || finish;
  assign take      = cmd_valid && cmd_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (take) state_nx = ST_SETUP;
      ST_SETUP:  state_nx = ST_ACCESS;
      ST_ACCESS: if (bus_rdy) state_nx = take ? ST_SETUP : ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      sel_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      state     <= state_nx;
      rsp_valid <= finish;
      if (take) begin
        addr_q  <= cmd_addr;
        wr_q    <= cmd_write;
        wdata_q <= cmd_write ? cmd_wdata : '0;
        sel_q   <= sel_dec;
      end
      if (finish) begin
        rsp_rdata <= wr_q ? '0 : bus_rdata;
        rsp_err   <= bus_err;
      end
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wr    = wr_q;
  assign bus_wdata = wdata_q;
  assign bus_sel   = (state == ST_IDLE) ? '0 : sel_q;
  assign bus_en    = (state == ST_ACCESS);

endmodule

module apb_xfer_ctrl_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_SLV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               rsp_valid,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_SLV-1:0] bus_sel,
  input logic               bus_en,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_rdy
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (bus_sel == '0 && !bus_en && !rsp_valid));

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  p_en_has_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (bus_sel != '0));

  p_setup_then_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel != '0 && !bus_en) |=> bus_en);

  p_setup_from_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (bus_sel != '0 && !bus_en));

  p_hold_into_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel != '0 && !bus_en) |=>
      ($stable(bus_addr) && $stable(bus_sel) && $stable(bus_wr) && $stable(bus_wdata)));

  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_rdy) |=>
      (bus_en && $stable(bus_addr) && $stable(bus_sel) && $stable(bus_wr) && $stable(bus_wdata)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rdy && !cmd_valid) |=> (bus_sel == '0 && !bus_en));

  p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rdy && cmd_valid) |=> (bus_sel != '0 && !bus_en));

  p_rsp_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rdy) |=> rsp_valid);

  p_rsp_only_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_en && bus_rdy));

  p_ready_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && bus_sel != '0) |-> (bus_en && bus_rdy));

endmodule

bind apb_xfer_ctrl apb_xfer_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLV(NUM_SLV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .bus_addr(bus_addr), .bus_sel(bus_sel),
  .bus_en(bus_en), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy)
);

// File: tb/test_apb_xfer_ctrl.sv
module test_apb_xfer_ctrl;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [IW-1:0] cmd_sel = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic [AW-1:0] bus_addr;
  logic [NS-1:0] bus_sel;
  logic          bus_en;
  logic          bus_wr;
  logic [DW-1:0] bus_wdata;
  logic          bus_rdy = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_err = 1'b0;

  always #5 clk = ~clk;

  apb_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_SLV(NS)) i_apb_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_sel(cmd_sel),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  int total = 0;
  int fails = 0;
  bit finished = 0;

  // bench model: 0 idle, 1 setup, 2 access
  int            m_st = 0;
  logic [AW-1:0] m_addr;
  logic          m_wr;
  logic [DW-1:0] m_wdata;
  logic [IW-1:0] m_sel;
  bit            e_rsp = 0;
  logic [DW-1:0] e_rdata;
  logic          e_err;
  bit            hs_prev = 0;
  int            b2b_cnt = 0;
  int            wait_run = 0;
  int            max_wait = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NS-1:0] exp_sel(int st, logic [IW-1:0] idx);
    return (st != 0) ? (NS'(1) << idx) : '0;
  endfunction

  function automatic logic [DW-1:0] exp_wdata(logic wr, logic [DW-1:0] d);
    return wr ? d : '0;
  endfunction

  task automatic run_phase(int n, int wait_pct, int valid_pct, int rst_at);
    for (int c = 0; c < n; c++) begin
      bit hs;
      bit done;
      @(negedge clk);
      chk("R2", "bus_sel", 64'(bus_sel), 64'(exp_sel(m_st, m_sel)));
      chk("R3", "bus_en", 64'(bus_en), 64'(m_st == 2));
      if (m_st != 0) begin
        chk("R4", "bus_addr", 64'(bus_addr), 64'(m_addr));
        chk("R11", "bus_wr", 64'(bus_wr), 64'(m_wr));
        chk("R11", "bus_wdata", 64'(bus_wdata), 64'(exp_wdata(m_wr, m_wdata)));
      end
      chk("R8", "rsp_valid", 64'(rsp_valid), 64'(e_rsp));
      if (e_rsp) begin
        chk("R8", "rsp_rdata", 64'(rsp_rdata), 64'(e_rdata));
        chk("R9", "rsp_err", 64'(rsp_err), 64'(e_err));
      end

      rst_n     = (c != rst_at);
      bus_rdy   = ($urandom_range(99) >= wait_pct);
      bus_rdata = $urandom;
      bus_err   = ($urandom_range(7) == 0);
      if (!cmd_valid || hs_prev) begin
        cmd_valid = ($urandom_range(99) < valid_pct);
        cmd_addr  = AW'($urandom);
        cmd_write = $urandom_range(1) == 1;
        cmd_wdata = $urandom;
        cmd_sel   = IW'($urandom_range(NS - 1));
      end
      #1;
      chk("R10", "cmd_ready", 64'(cmd_ready), 64'(m_st == 0 || (m_st == 2 && bus_rdy)));

      hs   = cmd_valid && cmd_ready;
      done = (m_st == 2) && bus_rdy;
      if (m_st == 2 && !bus_rdy) begin
        wait_run++;
        if (wait_run > max_wait) max_wait = wait_run;
      end else begin
        wait_run = 0;
      end
      e_rsp   = done;
      e_rdata = m_wr ? '0 : bus_rdata;
      e_err   = bus_err;
      if (done && hs) b2b_cnt++;
      case (m_st)
        0: m_st = hs ? 1 : 0;
        1: m_st = 2;
        default: if (bus_rdy) m_st = hs ? 1 : 0;
      endcase
      if (hs) begin
        m_addr = cmd_addr; m_wr = cmd_write; m_wdata = cmd_wdata; m_sel = cmd_sel;
      end
      hs_prev = hs;
      if (!rst_n) begin
        m_st = 0; e_rsp = 0; hs_prev = 0; wait_run = 0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1", "bus_sel in reset", 64'(bus_sel), 64'(0));
    chk("R1", "bus_en in reset", 64'(bus_en), 64'(0));
    chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'(0));
    chk("R1", "cmd_ready in reset", 64'(cmd_ready), 64'(1));
    // R7 back-to-back: peripheral always ready, commands always present
    run_phase(2000, 0, 100, -1);
    // R5 long wait stretches
    run_phase(2000, 92, 60, -1);
    // mixed traffic with a reset in the middle (R1, R6)
    run_phase(3000, 45, 70, 1500);
    chk("R7", "back-to-back handoffs seen", 64'(b2b_cnt > 100), 64'(1));
    chk("R5", "long wait run (>=10) seen", 64'(max_wait >= 10), 64'(1));
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog R1..all: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule